// File: doc/BRIEF.md
# Key-locked flash programming controller

This block lets a processor program and erase an on-chip flash array through a small register window. Software loads a byte target address and a 32-bit data word, picks an operation code and sets a write-enable bit. Next it writes a fixed three-word key into a dedicated register, and finally requests a start. The controller then holds its busy flag for a fixed number of cycles that depends on the operation. When that time is up it applies the result to an internal array model, lowers the busy flag by itself, and latches any error it found.

Error flags cannot be written directly. The only way to clear them is to run a NOP operation through the same enable-and-key ritual. Every start request, whether it is accepted or refused, spends the unlock, so each operation needs a fresh key sequence.

The register port is a plain single-cycle write strobe with a combinational read-back, so it never applies back-pressure. The array has its own read port, with one cycle of latency, for checking its contents. The array is organised as `PAGES` pages of `PAGE_BYTES` bytes. A product build uses 64 pages of 16 KB; the default parameters keep 64 pages but shrink each page to 64 bytes so the model stays small.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, the address and data registers read 0, the unlock is disarmed, and every array word reads 0xFFFF_FFFF.
- R2: The register offsets are: control at 0x00, clear alias at 0x04, set alias at 0x08, key at 0x10 (reads 0), byte target address at 0x20 (low `ADDR_W` bits are kept), and data word at 0x30. The control, clear-alias and set-alias offsets all read the same control word: op code in bits [3:0], bit 12 the low-voltage flag (always 0), bit 13 the write-error flag, bit 14 write enable, bit 15 busy/start.
- R3: A write to the set alias ORs bits [3:0] and bit 14 into the control word. A write to the clear alias clears the marked bits among [3:0] and 14. A direct control write with bit 15 at 0 loads bits [3:0] and 14. No write of any kind changes bits 12 or 13, and bit 15 in a clear-alias write has no effect.
- R4: A control or set-alias write with bit 15 at 1 is a start request and changes no other field. The request is accepted only when the key register has received 0x0000_0000, 0xAA99_6655 and 0x5566_99AA, in that order, since the last disarm. A key write that does not match the next expected value returns the unlock to its initial state.
- R5: A start request made while idle and either not unlocked or with write enable clear leaves busy at 0 and sets the write-error flag.
- R6: Every start request disarms the unlock, so a following start needs the key sequence again.
- R7: After an accepted start, busy reads 1 for exactly `PROG_CYCLES` (op 0x1), `ERASE_CYCLES` (op 0x4) or `NOP_CYCLES` (any other code) cycles, counted from the accepting edge, and then reads 0.
- R8: Program (op 0x1) stores the data word at the target word. If any bit would need to change from 0 to 1, the word is left unchanged and the write-error flag is set.
- R9: Erase (op 0x4) sets every word of the page selected by the target address bits above the page offset to 0xFFFF_FFFF, and leaves other pages unchanged.
- R10: A completed NOP (op 0x0) clears the write-error flag.
- R11: While busy reads 1, writes to the address register, the data register and the op-code field are ignored. This includes a write that lands on the edge where busy falls.
- R12: An op code other than 0x0, 0x1 or 0x4 sets the write-error flag on completion and leaves the array unchanged.
- R13: The array read port returns the word selected by `fr_word` one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Register offset for write and read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read-back of the register at bus_addr |
| fr_word | input | ADDR_W-2 | Array word index for the read port |
| fr_data | output | 32 | Array word, one cycle after fr_word |

## Verification
Two things can coincide: the edge on which an operation completes and busy falls, and a software write to the target address register. The bench times an address write so that it is captured on exactly that completing edge. It then checks that busy reads 0 and that the address still holds its old value, and it checks that a write one cycle later does take effect. A second overlap, a start request arriving while the unlock is only partly entered, is provoked by breaking the key sequence and is judged by busy staying low while the error flag rises.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
  localparam logic [OP_W-1:0] OP_PROG  = 4'h1;
  localparam logic [OP_W-1:0] OP_ERASE = 4'h4;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CLR  = 8'h04;
  localparam logic [7:0] OFS_SET  = 8'h08;
  localparam logic [7:0] OFS_KEY  = 8'h10;
  localparam logic [7:0] OFS_ADDR = 8'h20;
  localparam logic [7:0] OFS_DATA = 8'h30;

  localparam int BIT_WR    = 15;
  localparam int BIT_WREN  = 14;
  localparam int BIT_WERR  = 13;
  localparam int BIT_LVERR = 12;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0000;
  localparam logic [31:0] KEY_SECOND = 32'hAA99_6655;
  localparam logic [31:0] KEY_THIRD  = 32'h5566_99AA;

  typedef enum logic [1:0] {
    K_IDLE,
    K_GOT1,
    K_GOT2,
    K_ARMED
  } key_state_t;
endpackage

// File: rtl/fpc_unlock.sv
`timescale 1ns/1ps
module fpc_unlock
  import fpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        disarm,
  output logic        armed
);
  key_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= K_IDLE;
    end else if (disarm) begin
      st <= K_IDLE;
    end else if (key_we) begin
      unique case (st)
        K_IDLE:  st <= (key_data == KEY_FIRST)  ? K_GOT1  : K_IDLE;
        K_GOT1:  st <= (key_data == KEY_SECOND) ? K_GOT2  : K_IDLE;
        K_GOT2:  st <= (key_data == KEY_THIRD)  ? K_ARMED : K_IDLE;
        default: st <= K_IDLE;
      endcase
    end
  end

  assign armed = (st == K_ARMED);
endmodule

// File: rtl/fpc_sequencer.sv
`timescale 1ns/1ps
module fpc_sequencer
  import fpc_pkg::*;
#(
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 12,
  parameter int NOP_CYCLES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            armed,
  input  logic            wren,
  input  logic [OP_W-1:0] op,
  input  logic            conflict,
  output logic            busy,
  output logic            exec,
  output logic            werr
);
  localparam int MAX_AB = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_C  = (MAX_AB > NOP_CYCLES) ? MAX_AB : NOP_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] NOP_LD   = CNT_W'(NOP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             op_known;

  always_comb begin
    unique case (op)
      OP_PROG:  load_val = PROG_LD;
      OP_ERASE: load_val = ERASE_LD;
      default:  load_val = NOP_LD;
    endcase
    op_known = (op == OP_NOP) || (op == OP_PROG) || (op == OP_ERASE);
  end

  assign exec = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      werr <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        if (op == OP_NOP)
          werr <= 1'b0;
        else if (!op_known)
          werr <= 1'b1;
        else if ((op == OP_PROG) && conflict)
          werr <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start_req) begin
      if (armed && wren) begin
        busy <= 1'b1;
        cnt  <= load_val;
      end else begin
        werr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpc_array.sv
`timescale 1ns/1ps
module fpc_array
  import fpc_pkg::*;
#(
  parameter int PAGES      = 64,
  parameter int PAGE_WORDS = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   exec,
  input  logic [OP_W-1:0]                        op,
  input  logic [$clog2(PAGES*PAGE_WORDS)-1:0]    widx,
  input  logic [31:0]                            wdata,
  input  logic [$clog2(PAGES*PAGE_WORDS)-1:0]    rd_idx,
  output logic                                   conflict,
  output logic [31:0]                            rd_data
);
  localparam int WORDS  = PAGES * PAGE_WORDS;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int PW_W   = $clog2(PAGE_WORDS);

  logic [31:0] mem [WORDS];
  logic [WIDX_W-PW_W-1:0] page_sel;

  assign page_sel = widx[WIDX_W-1:PW_W];
  assign conflict = ((mem[widx] & wdata) != wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      rd_data <= '1;
    end else begin
      rd_data <= mem[rd_idx];
      if (exec && (op == OP_PROG) && !conflict)
        mem[widx] <= wdata;
      if (exec && (op == OP_ERASE))
        for (int p = 0; p < PAGE_WORDS; p++)
          mem[{page_sel, PW_W'(p)}] <= '1;
    end
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
`timescale 1ns/1ps
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int PAGES        = 64,
  parameter int PAGE_BYTES   = 64,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 12,
  parameter int NOP_CYCLES   = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       bus_we,
  input  logic [7:0]                                 bus_addr,
  input  logic [31:0]                                bus_wdata,
  output logic [31:0]                                bus_rdata,
  input  logic [$clog2(PAGES*PAGE_BYTES)-3:0]        fr_word,
  output logic [31:0]                                fr_data
);
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int ADDR_W     = $clog2(PAGES * PAGE_BYTES);

  logic              wr_ctrl, wr_set, wr_clr, wr_key, wr_addr, wr_data;
  logic              start_req;
  logic              key_armed;
  logic              busy, exec, werr, conflict;
  logic              wren_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic [31:0]       ctrl_word;

  assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
  assign wr_set    = bus_we && (bus_addr == OFS_SET);
  assign wr_clr    = bus_we && (bus_addr == OFS_CLR);
  assign wr_key    = bus_we && (bus_addr == OFS_KEY);
  assign wr_addr   = bus_we && (bus_addr == OFS_ADDR);
  assign wr_data   = bus_we && (bus_addr == OFS_DATA);
  assign start_req = (wr_ctrl || wr_set) && bus_wdata[BIT_WR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl && !start_req) begin
        wren_q <= bus_wdata[BIT_WREN];
        if (!busy) op_q <= bus_wdata[OP_W-1:0];
      end else if (wr_set && !start_req) begin
        if (bus_wdata[BIT_WREN]) wren_q <= 1'b1;
        if (!busy) op_q <= op_q | bus_wdata[OP_W-1:0];
      end else if (wr_clr) begin
        if (bus_wdata[BIT_WREN]) wren_q <= 1'b0;
        if (!busy) op_q <= op_q & ~bus_wdata[OP_W-1:0];
      end
      if (wr_addr && !busy) addr_q <= bus_wdata[ADDR_W-1:0];
      if (wr_data && !busy) data_q <= bus_wdata;
    end
  end

  fpc_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (wr_key),
    .key_data (bus_wdata),
    .disarm   (start_req),
    .armed    (key_armed)
  );

  fpc_sequencer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .NOP_CYCLES   (NOP_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .armed     (key_armed),
    .wren      (wren_q),
    .op        (op_q),
    .conflict  (conflict),
    .busy      (busy),
    .exec      (exec),
    .werr      (werr)
  );

  fpc_array #(
    .PAGES      (PAGES),
    .PAGE_WORDS (PAGE_WORDS)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec     (exec),
    .op       (op_q),
    .widx     (addr_q[ADDR_W-1:2]),
    .wdata    (data_q),
    .rd_idx   (fr_word),
    .conflict (conflict),
    .rd_data  (fr_data)
  );

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[OP_W-1:0]    = op_q;
    ctrl_word[BIT_LVERR]   = 1'b0;
    ctrl_word[BIT_WERR]    = werr;
    ctrl_word[BIT_WREN]    = wren_q;
    ctrl_word[BIT_WR]      = busy;
    unique case (bus_addr)
      OFS_CTRL, OFS_SET, OFS_CLR: bus_rdata = ctrl_word;
      OFS_ADDR:                   bus_rdata = 32'(addr_q);
      OFS_DATA:                   bus_rdata = data_q;
      default:                    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fpc_checker.sv
`timescale 1ns/1ps
module fpc_checker
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [7:0]        bus_addr,
  input logic              busy,
  input logic              armed,
  input logic              wren_q,
  input logic              werr,
  input logic              start_req,
  input logic              exec,
  input logic [OP_W-1:0]   op_q,
  input logic              conflict,
  input logic [ADDR_W-1:0] addr_q,
  input logic [31:0]       data_q
);
  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(armed) && $past(wren_q))); // R4

  AST_ARM_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !armed); // R6

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && !(armed && wren_q)) |=> (werr && !busy)); // R5

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !busy); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && (bus_addr == OFS_ADDR)) |=> $stable(addr_q)); // R11

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && (bus_addr == OFS_DATA)) |=> $stable(data_q)); // R11

  AST_CONFLICT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op_q == OP_PROG) && conflict) |=> werr); // R8

  AST_NOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op_q == OP_NOP)) |=> !werr); // R10
endmodule

bind flash_prog_ctrl fpc_checker #(.ADDR_W(ADDR_W)) u_fpc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .busy      (busy),
  .armed     (key_armed),
  .wren_q    (wren_q),
  .werr      (werr),
  .start_req (start_req),
  .exec      (exec),
  .op_q      (op_q),
  .conflict  (conflict),
  .addr_q    (addr_q),
  .data_q    (data_q)
);

// File: tb/flash_prog_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prog_ctrl_bench;
  localparam int PROG_C  = 4;
  localparam int ERASE_C = 12;
  localparam int NOP_C   = 2;
  localparam logic [31:0] WR_B = 32'h0000_8000;
  localparam logic [31:0] WE_B = 32'h0000_4000;
  localparam logic [31:0] ER_B = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  fr_word = '0;
  logic [31:0] fr_data;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(
    .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C), .NOP_CYCLES(NOP_C)
  ) u_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fr_word(fr_word), .fr_data(fr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic fread(input logic [31:0] byte_a, output logic [31:0] d);
    @(negedge clk);
    fr_word = byte_a[11:2];
    @(negedge clk);
    d = fr_data;
  endtask

  task automatic unlock();
    wr(8'h10, 32'h0000_0000);
    wr(8'h10, 32'hAA99_6655);
    wr(8'h10, 32'h5566_99AA);
  endtask

  task automatic set_op(input logic [3:0] op);
    wr(8'h04, 32'h0000_400F);
    wr(8'h08, WE_B | 32'(op));
  endtask

  // returns half a cycle after the accepting edge
  task automatic launch(input logic [3:0] op);
    set_op(op);
    unlock();
    wr(8'h00, WR_B);
  endtask

  task automatic wait_done(input int dur, input string tag);
    logic [31:0] v;
    rd(8'h00, v); chk({tag, " busy after start"}, v & WR_B, WR_B);
    repeat (dur - 1) @(negedge clk);
    rd(8'h00, v); chk({tag, " busy on last cycle"}, v & WR_B, WR_B);
    @(negedge clk);
    rd(8'h00, v); chk({tag, " busy cleared"}, v & WR_B, 32'h0);
  endtask

  task automatic clear_err(input string tag);
    logic [31:0] v;
    launch(4'h0);
    wait_done(NOP_C, {tag, " R7 nop"});
    rd(8'h00, v); chk({tag, " R10 nop clears error"}, v & ER_B, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl reset", v, 32'h0);
    rd(8'h20, v); chk("R1 addr reset", v, 32'h0);
    rd(8'h30, v); chk("R1 data reset", v, 32'h0);
    fread(32'h0, v);   chk("R1 array word 0 erased", v, 32'hFFFF_FFFF);
    fread(32'hFFC, v); chk("R1 array last word erased", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h20, 32'hFFFF_F123); rd(8'h20, v); chk("R2 addr keeps low bits", v, 32'h0000_0123);
    wr(8'h30, 32'hCAFE_0001); rd(8'h30, v); chk("R2 data readback", v, 32'hCAFE_0001);
    rd(8'h10, v); chk("R2 key reads zero", v, 32'h0);
    wr(8'h08, 32'h0000_4005); rd(8'h08, v); chk("R3 set alias", v, 32'h0000_4005);
    wr(8'h04, 32'h0000_0001); rd(8'h04, v); chk("R3 clear alias op bit", v, 32'h0000_4004);
    wr(8'h04, 32'h0000_C000); rd(8'h00, v); chk("R3 clear alias wren, bit15 inert", v, 32'h0000_0004);
    wr(8'h00, 32'h0000_3002); rd(8'h00, v); chk("R3 error bits not writable", v, 32'h0000_0002);
  endtask

  task automatic t_program();
    logic [31:0] v;
    wr(8'h20, 32'h40); wr(8'h30, 32'h1234_5678);
    launch(4'h1);
    wait_done(PROG_C, "R7 program");
    fread(32'h40, v); chk("R8 R13 programmed word", v, 32'h1234_5678);
    rd(8'h00, v); chk("R8 no error on clean program", v & ER_B, 32'h0);
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    wr(8'h30, 32'h1234_5679);
    launch(4'h1);
    wait_done(PROG_C, "R7 conflict program");
    rd(8'h00, v);     chk("R8 zero-to-one sets error", v & ER_B, ER_B);
    fread(32'h40, v); chk("R8 word unchanged on conflict", v, 32'h1234_5678);
    wr(8'h30, 32'h1234_5670);
    launch(4'h1);
    wait_done(PROG_C, "R7 subset program");
    fread(32'h40, v); chk("R8 clearing bits allowed", v, 32'h1234_5670);
    rd(8'h00, v);     chk("R10 error sticky until nop", v & ER_B, ER_B);
    clear_err("conflict");
  endtask

  task automatic t_badkey();
    logic [31:0] v;
    set_op(4'h0);
    wr(8'h10, 32'h0000_0000); wr(8'h10, 32'hAA99_6655);
    wr(8'h10, 32'h0000_0000); wr(8'h10, 32'h5566_99AA);
    wr(8'h00, WR_B);
    rd(8'h00, v); chk("R4 broken key refuses start", v & WR_B, 32'h0);
    chk("R5 refused start sets error", v & ER_B, ER_B);
    clear_err("badkey");
    unlock(); wr(8'h10, 32'h0000_0000);
    wr(8'h00, WR_B);
    rd(8'h00, v); chk("R4 key write after arming disarms", v & WR_B, 32'h0);
    clear_err("overkey");
  endtask

  task automatic t_nowren();
    logic [31:0] v;
    set_op(4'h0);
    wr(8'h04, WE_B);
    unlock();
    wr(8'h08, WR_B);
    rd(8'h00, v); chk("R5 start without wren refused", v & (WR_B | ER_B), ER_B);
    wr(8'h08, WE_B);
    wr(8'h08, WR_B);
    rd(8'h00, v); chk("R6 refused start spends unlock", v & WR_B, 32'h0);
    clear_err("nowren");
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(8'h20, 32'h80); wr(8'h30, 32'h0F0F_0F0F);
    launch(4'h1);
    wait_done(PROG_C, "R7 oneshot program");
    wr(8'h00, WR_B);
    rd(8'h00, v); chk("R6 second start needs new key", v & (WR_B | ER_B), ER_B);
    clear_err("oneshot");
  endtask

  task automatic t_erase();
    logic [31:0] v;
    wr(8'h20, 32'h44);
    launch(4'h4);
    wait_done(ERASE_C, "R7 erase");
    fread(32'h40, v); chk("R9 page word erased", v, 32'hFFFF_FFFF);
    fread(32'h80, v); chk("R9 neighbour page untouched", v, 32'h0F0F_0F0F);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(8'h20, 32'h80);
    launch(4'h4);
    wr(8'h30, 32'hDEAD_BEEF);
    wr(8'h04, 32'h0000_000F);
    rd(8'h30, v); chk("R11 data held while busy", v, 32'h0F0F_0F0F);
    rd(8'h00, v); chk("R11 op held while busy", v & 32'hF, 32'h4);
    // 0.5 + 2 + 2 cycles have passed; land the next write on edge ERASE_C
    repeat (ERASE_C - 6) @(negedge clk);
    wr(8'h20, 32'h300);
    rd(8'h00, v); chk("R7 busy cleared at completion edge", v & WR_B, 32'h0);
    rd(8'h20, v); chk("R11 addr write on completion edge ignored", v, 32'h80);
    fread(32'h80, v); chk("R9 second page erased", v, 32'hFFFF_FFFF);
    wr(8'h20, 32'h300);
    rd(8'h20, v); chk("R11 addr accepted once idle", v, 32'h300);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    wr(8'h20, 32'h0); wr(8'h30, 32'h0);
    launch(4'h2);
    wait_done(NOP_C, "R7 invalid op");
    rd(8'h00, v);    chk("R12 unknown op sets error", v & ER_B, ER_B);
    fread(32'h0, v); chk("R12 array unchanged", v, 32'hFFFF_FFFF);
    clear_err("invalid");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_program();
    t_conflict();
    t_badkey();
    t_nowren();
    t_oneshot();
    t_erase();
    t_busy();
    t_invalid();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule